// File: doc/BRIEF.md
# Accumulator ALU with Flag File

This block is the datapath arithmetic unit of an 8-bit accumulator machine. Each cycle the surrounding core presents the accumulator, a second byte operand, a carry input and a 4-bit operation code. The byte result appears combinationally on `result_o`. A write-enable says where the result belongs: the accumulator for most operations, the selected general register for increment and decrement, or nowhere for compare. A separate 16-bit path adds a register pair to the HL pair for the core to write back.

The five condition flags are held in a registered flag file. On the clock edge that accepts an operation, the flags that the operation owns are updated and all others are kept. The flag byte is always visible with a fixed bit layout, so the core can store it next to the accumulator.

Top module: `acc_alu`

## Requirements
- R1: Reset (rst_ni low) sets `flags_o` to 8'h02. The flag byte layout is S = bit 7, Z = bit 6, AC = bit 4, P = bit 2, CY = bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1.
- R2: Op 0 (add) gives acc+opnd and op 1 (add with carry) gives acc+opnd+carry_i, both with `acc_we_o` high. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R3: Op 2 (subtract) gives acc-opnd and op 3 (subtract with borrow) gives acc-opnd-carry_i, in two's complement with `acc_we_o` high. CY is set when opnd (+carry_i) exceeds acc unsigned. AC is set when the low nibble of opnd (+carry_i) exceeds the low nibble of acc.
- R4: For ops 0-7, 13 and 14, Z is set when the byte result is zero, S copies result bit 7, and P is set when the result has an even number of ones.
- R5: Ops 4 (AND), 5 (XOR) and 6 (OR) combine acc with opnd, write the accumulator, and clear both CY and AC.
- R6: Op 7 (compare) sets all flags exactly as subtract does. All write-enables stay low.
- R7: Op 12 (complement) gives ~acc with `acc_we_o` high and changes no flag.
- R8: Op 8 rotates acc left circularly. Op 9 rotates it right circularly. Op 10 rotates left through carry_i, and op 11 rotates right through carry_i. In every case CY takes the bit shifted out, the other flags are kept, and `acc_we_o` is high.
- R9: Op 13 gives opnd+1 and op 14 gives opnd-1 on `result_o` with `dst_we_o` high and `acc_we_o` low. CY is kept. AC is the carry out of the low nibble for op 13 and the borrow into it for op 14.
- R10: Op 15 drives `hl_o` = hl_i + pair_i with `hl_we_o` high. Only CY changes, and it takes the carry out of bit 15.
- R11: With `valid_i` low, all three write-enables are low and `flags_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe for this cycle |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand, or the register for increment/decrement |
| carry_i | input | 1 | Carry input for add/subtract with carry and rotates through carry |
| pair_i | input | 16 | Register pair added to HL |
| hl_i | input | 16 | Current HL pair |
| result_o | output | 8 | Byte result |
| acc_we_o | output | 1 | Write result to accumulator |
| dst_we_o | output | 1 | Write result to the increment/decrement register |
| hl_o | output | 16 | 16-bit sum for HL |
| hl_we_o | output | 1 | Write hl_o to HL |
| flags_o | output | 8 | Registered flag byte |

## Verification
The assertions assume that `op_i` and `valid_i` are stable around the clock edge. They also assume that each accepted operation sees the flag register left by the previous one, so every before-and-after flag relation is measured over one edge. The bench changes inputs only on falling edges, holds each operation for exactly one rising edge, and then lowers `valid_i`. It separates operations with idle cycles, during which the held-flag properties are checked with no other activity.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  parameter int unsigned DW = 8;
  parameter int unsigned PW = 2 * DW;
  parameter int unsigned NF = 5;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_AND = 4'd4,  OP_XOR = 4'd5,  OP_OR  = 4'd6,  OP_CMP = 4'd7,
    OP_RLC = 4'd8,  OP_RRC = 4'd9,  OP_RAL = 4'd10, OP_RAR = 4'd11,
    OP_CMA = 4'd12, OP_INR = 4'd13, OP_DCR = 4'd14, OP_DAD = 4'd15
  } alu_op_e;

  // index into the internal flag vector
  localparam int FI_CY = 0;
  localparam int FI_P  = 1;
  localparam int FI_AC = 2;
  localparam int FI_Z  = 3;
  localparam int FI_S  = 4;

  // bit positions in the visible flag byte
  localparam int FB_CY  = 0;
  localparam int FB_ONE = 1;
  localparam int FB_P   = 2;
  localparam int FB_AC  = 4;
  localparam int FB_Z   = 6;
  localparam int FB_S   = 7;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W  = 8,
  parameter int unsigned HB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         hc_o
);
  logic [W-1:0] b_x;
  logic         c_x;
  logic [W:0]   full;
  logic [HB:0]  half;

  // subtract as a + ~b + ~borrow; carries invert into borrows
  always_comb begin
    b_x    = sub_i ? ~b_i : b_i;
    c_x    = sub_i ? ~cin_i : cin_i;
    full   = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, c_x};
    half   = {1'b0, a_i[HB-1:0]} + {1'b0, b_x[HB-1:0]} + {{HB{1'b0}}, c_x};
    sum_o  = full[W-1:0];
    cout_o = sub_i ? ~full[W] : full[W];
    hc_o   = sub_i ? ~half[HB] : half[HB];
  end
endmodule

// File: rtl/alu_pair_add.sv
module alu_pair_add #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/alu_flag_file.sv
module alu_flag_file #(
  parameter int unsigned  NF    = 5,
  parameter logic [NF-1:0] RST_V = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] upd_i,
  input  logic [NF-1:0] nxt_i,
  output logic [NF-1:0] q_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= RST_V[g];
      else if (upd_i[g]) q_o[g] <= nxt_i[g];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          carry_i,
  input  logic [PW-1:0] pair_i,
  input  logic [PW-1:0] hl_i,
  output logic [DW-1:0] result_o,
  output logic          acc_we_o,
  output logic          dst_we_o,
  output logic [PW-1:0] hl_o,
  output logic          hl_we_o,
  output logic [7:0]    flags_o
);
  localparam logic [NF-1:0] ALL_F = '1;
  localparam logic [NF-1:0] CY_F  = NF'(1) << FI_CY;

  alu_op_e       op;
  logic [DW-1:0] as_a, as_b, as_sum;
  logic          as_cin, as_sub, as_cout, as_hc;
  logic          pr_cout;
  logic [DW-1:0] res;
  logic [NF-1:0] upd, nxt, fq;
  logic          acc_we_d, dst_we_d, hl_we_d;
  logic          cy_n, ac_n;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.W(DW), .HB(4)) u_addsub (
    .a_i(as_a), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .cout_o(as_cout), .hc_o(as_hc)
  );

  alu_pair_add #(.W(PW)) u_pair (
    .a_i(hl_i), .b_i(pair_i), .sum_o(hl_o), .cout_o(pr_cout)
  );

  always_comb begin
    as_a     = acc_i;
    as_b     = opnd_i;
    as_cin   = 1'b0;
    as_sub   = 1'b0;
    res      = as_sum;
    cy_n     = as_cout;
    ac_n     = as_hc;
    upd      = '0;
    acc_we_d = 1'b0;
    dst_we_d = 1'b0;
    hl_we_d  = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        as_cin = (op == OP_ADC) & carry_i;
        upd = ALL_F; acc_we_d = 1'b1;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        as_sub = 1'b1;
        as_cin = (op == OP_SBB) & carry_i;
        upd = ALL_F; acc_we_d = (op != OP_CMP);
      end
      OP_AND, OP_XOR, OP_OR: begin
        res  = (op == OP_AND) ? (acc_i & opnd_i) :
               (op == OP_XOR) ? (acc_i ^ opnd_i) : (acc_i | opnd_i);
        cy_n = 1'b0; ac_n = 1'b0;
        upd = ALL_F; acc_we_d = 1'b1;
      end
      OP_RLC, OP_RAL: begin
        res  = {acc_i[DW-2:0], (op == OP_RLC) ? acc_i[DW-1] : carry_i};
        cy_n = acc_i[DW-1];
        upd = CY_F; acc_we_d = 1'b1;
      end
      OP_RRC, OP_RAR: begin
        res  = {(op == OP_RRC) ? acc_i[0] : carry_i, acc_i[DW-1:1]};
        cy_n = acc_i[0];
        upd = CY_F; acc_we_d = 1'b1;
      end
      OP_CMA: begin
        res = ~acc_i;
        acc_we_d = 1'b1;
      end
      OP_INR, OP_DCR: begin
        as_a   = opnd_i;
        as_b   = DW'(1);
        as_sub = (op == OP_DCR);
        upd = ALL_F & ~CY_F; dst_we_d = 1'b1;
      end
      OP_DAD: begin
        res  = '0;
        cy_n = pr_cout;
        upd = CY_F; hl_we_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    nxt        = '0;
    nxt[FI_CY] = cy_n;
    nxt[FI_AC] = ac_n;
    nxt[FI_Z]  = (res == '0);
    nxt[FI_S]  = res[DW-1];
    nxt[FI_P]  = ~^res;
  end

  alu_flag_file #(.NF(NF), .RST_V('0)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .upd_i(upd & {NF{valid_i}}), .nxt_i(nxt), .q_o(fq)
  );

  always_comb begin
    flags_o         = '0;
    flags_o[FB_ONE] = 1'b1;
    flags_o[FB_CY]  = fq[FI_CY];
    flags_o[FB_P]   = fq[FI_P];
    flags_o[FB_AC]  = fq[FI_AC];
    flags_o[FB_Z]   = fq[FI_Z];
    flags_o[FB_S]   = fq[FI_S];
  end

  assign result_o = res;
  assign acc_we_o = valid_i & acc_we_d;
  assign dst_we_o = valid_i & dst_we_d;
  assign hl_we_o  = valid_i & hl_we_d;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [3:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] opnd_i,
  input logic [DW-1:0] result_o,
  input logic          acc_we_o,
  input logic          dst_we_o,
  input logic          hl_we_o,
  input logic [7:0]    flags_o
);
  // R1
  flag_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b1);

  // R2
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ADD) |-> (result_o == DW'(acc_i + opnd_i)) && acc_we_o);

  // R5
  logic_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR))
      |=> (flags_o[0] == 1'b0 && flags_o[4] == 1'b0));

  // R6
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CMP) |-> !acc_we_o && !dst_we_o && !hl_we_o);

  // R7
  cma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CMA) |=> flags_o == $past(flags_o));

  // R8
  rot_only_cy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i >= OP_RLC && op_i <= OP_RAR) |=> flags_o[7:1] == $past(flags_o[7:1]));

  // R9
  incdec_keep_cy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_INR || op_i == OP_DCR)) |=> flags_o[0] == $past(flags_o[0]));

  // R10
  dad_only_cy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_DAD) |=> flags_o[7:1] == $past(flags_o[7:1]));

  // R11
  idle_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !acc_we_o && !dst_we_o && !hl_we_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o));

  // R6
  we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_we_o, dst_we_o, hl_we_o}));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o),
  .acc_we_o(acc_we_o), .dst_we_o(dst_we_o), .hl_we_o(hl_we_o),
  .flags_o(flags_o)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [7:0]  acc_i = '0, opnd_i = '0;
  logic        carry_i = 1'b0;
  logic [15:0] pair_i = '0, hl_i = '0;
  logic [7:0]  result_o;
  logic        acc_we_o, dst_we_o, hl_we_o;
  logic [15:0] hl_o;
  logic [7:0]  flags_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] ef = 8'h02;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  acc_alu u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i), .pair_i(pair_i),
    .hl_i(hl_i), .result_o(result_o), .acc_we_o(acc_we_o),
    .dst_we_o(dst_we_o), .hl_o(hl_o), .hl_we_o(hl_we_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one operation, check combinational outputs, then flags after the edge
  task automatic run_op(input string req, input logic [3:0] op,
                        input logic [7:0] a, input logic [7:0] b, input logic cin,
                        input logic [15:0] pr, input logic [15:0] hl);
    logic [7:0] er = '0, nf;
    logic [15:0] eh = '0;
    logic [16:0] t16;
    logic ea = 0, ed = 0, eh_we = 0, szp = 0, ci;
    nf = ef;
    case (op)
      4'd0, 4'd1: begin
        ci = (op == 4'd1) ? cin : 1'b0;
        er = a + b + 8'(ci);
        nf[0] = (int'(a) + int'(b) + int'(ci)) > 255;
        nf[4] = (int'(a[3:0]) + int'(b[3:0]) + int'(ci)) > 15;
        szp = 1; ea = 1;
      end
      4'd2, 4'd3, 4'd7: begin
        ci = (op == 4'd3) ? cin : 1'b0;
        er = a - b - 8'(ci);
        nf[0] = (int'(b) + int'(ci)) > int'(a);
        nf[4] = (int'(b[3:0]) + int'(ci)) > int'(a[3:0]);
        szp = 1; ea = (op != 4'd7);
      end
      4'd4: begin er = a & b; nf[0] = 0; nf[4] = 0; szp = 1; ea = 1; end
      4'd5: begin er = a ^ b; nf[0] = 0; nf[4] = 0; szp = 1; ea = 1; end
      4'd6: begin er = a | b; nf[0] = 0; nf[4] = 0; szp = 1; ea = 1; end
      4'd8:  begin er = {a[6:0], a[7]}; nf[0] = a[7]; ea = 1; end
      4'd9:  begin er = {a[0], a[7:1]}; nf[0] = a[0]; ea = 1; end
      4'd10: begin er = {a[6:0], cin};  nf[0] = a[7]; ea = 1; end
      4'd11: begin er = {cin, a[7:1]};  nf[0] = a[0]; ea = 1; end
      4'd12: begin er = ~a; ea = 1; end
      4'd13: begin er = b + 8'd1; nf[4] = (b[3:0] == 4'hF); szp = 1; ed = 1; end
      4'd14: begin er = b - 8'd1; nf[4] = (b[3:0] == 4'h0); szp = 1; ed = 1; end
      default: begin
        t16 = {1'b0, hl} + {1'b0, pr};
        eh = t16[15:0]; nf[0] = t16[16]; eh_we = 1;
      end
    endcase
    if (szp) begin
      nf[6] = (er == 8'h00);
      nf[7] = er[7];
      nf[2] = ~^er;
    end
    @(negedge clk_i);
    op_i = op; acc_i = a; opnd_i = b; carry_i = cin; pair_i = pr; hl_i = hl;
    valid_i = 1'b1;
    #2;
    if (op != 4'd15) chk(req, "result", 16'(result_o), 16'(er));
    else chk(req, "hl", hl_o, eh);
    chk(req, "we{acc,dst,hl}", 16'({acc_we_o, dst_we_o, hl_we_o}), 16'({ea, ed, eh_we}));
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(req, "flags", 16'(flags_o), 16'(nf));
    ef = nf;
  endtask

  task automatic t_reset();
    #5;
    chk("R1", "flags in reset", 16'(flags_o), 16'h0002);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "flags after reset", 16'(flags_o), 16'h0002);
  endtask

  task automatic t_add();
    run_op("R2", 4'd0, 8'h3A, 8'h26, 1'b1, '0, '0); // 60, AC set, parity even
    run_op("R2", 4'd0, 8'hFF, 8'h01, 1'b0, '0, '0); // zero, CY, AC
    run_op("R2", 4'd1, 8'h7F, 8'h00, 1'b1, '0, '0); // carry-in to 80, sign
    run_op("R4", 4'd1, 8'h10, 8'h20, 1'b0, '0, '0); // parity even 30
    run_op("R4", 4'd0, 8'h01, 8'h00, 1'b0, '0, '0); // odd parity
  endtask

  task automatic t_sub();
    run_op("R3", 4'd2, 8'h05, 8'h03, 1'b0, '0, '0);
    run_op("R3", 4'd2, 8'h03, 8'h05, 1'b0, '0, '0); // negative, borrow
    run_op("R3", 4'd3, 8'h10, 8'h0F, 1'b1, '0, '0); // zero, half borrow
    run_op("R3", 4'd3, 8'h00, 8'hFF, 1'b1, '0, '0); // borrow with carry in
    run_op("R3", 4'd2, 8'h80, 8'h80, 1'b1, '0, '0); // carry_i ignored on op 2
  endtask

  task automatic t_logic();
    run_op("R5", 4'd0, 8'hF8, 8'h0F, 1'b0, '0, '0); // set CY and AC first
    run_op("R5", 4'd4, 8'hF0, 8'h3C, 1'b0, '0, '0);
    run_op("R5", 4'd0, 8'hF8, 8'h0F, 1'b0, '0, '0);
    run_op("R5", 4'd5, 8'hAA, 8'hAA, 1'b1, '0, '0);
    run_op("R5", 4'd6, 8'h81, 8'h02, 1'b0, '0, '0);
  endtask

  task automatic t_cmp();
    run_op("R6", 4'd7, 8'h20, 8'h21, 1'b0, '0, '0);
    run_op("R6", 4'd7, 8'h42, 8'h42, 1'b1, '0, '0);
  endtask

  task automatic t_cma();
    run_op("R7", 4'd2, 8'h00, 8'h01, 1'b0, '0, '0); // non-trivial flags
    run_op("R7", 4'd12, 8'h5A, 8'h00, 1'b0, '0, '0);
    run_op("R7", 4'd12, 8'hFF, 8'h00, 1'b1, '0, '0);
  endtask

  task automatic t_rot();
    run_op("R8", 4'd8,  8'h81, 8'h00, 1'b0, '0, '0);
    run_op("R8", 4'd9,  8'h02, 8'h00, 1'b1, '0, '0);
    run_op("R8", 4'd10, 8'h40, 8'h00, 1'b1, '0, '0);
    run_op("R8", 4'd11, 8'h01, 8'h00, 1'b0, '0, '0);
  endtask

  task automatic t_incdec();
    run_op("R9", 4'd0, 8'hFF, 8'h01, 1'b0, '0, '0); // CY=1 to see it kept
    run_op("R9", 4'd13, 8'h55, 8'hFF, 1'b0, '0, '0);
    run_op("R9", 4'd13, 8'h00, 8'h0F, 1'b0, '0, '0);
    run_op("R9", 4'd14, 8'h00, 8'h00, 1'b0, '0, '0);
    run_op("R9", 4'd14, 8'h00, 8'h01, 1'b0, '0, '0);
  endtask

  task automatic t_dad();
    run_op("R10", 4'd2, 8'h00, 8'h01, 1'b0, '0, '0);
    run_op("R10", 4'd15, 8'h00, 8'h00, 1'b0, 16'h0001, 16'hFFFF);
    run_op("R10", 4'd15, 8'h00, 8'h00, 1'b1, 16'h1234, 16'h4321);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    op_i = 4'd0; acc_i = 8'hFF; opnd_i = 8'h01; carry_i = 1'b1;
    pair_i = 16'hFFFF; hl_i = 16'h0001; valid_i = 1'b0;
    #2;
    chk("R11", "we idle", 16'({acc_we_o, dst_we_o, hl_we_o}), 16'h0);
    @(negedge clk_i);
    op_i = 4'd15;
    @(negedge clk_i);
    chk("R11", "flags idle", 16'(flags_o), 16'(ef));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_cmp();
    t_cma();
    t_rot();
    t_incdec();
    t_dad();
    t_idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule